// File: doc/BRIEF.md
# Line-Frequency Tick Status Register

This block holds the single control and status word of a periodic tick source, such as a mains-frequency clock that paces a scheduler. Each tick sets a done flag. If software has set the enable flag, the tick also raises an interrupt request. Software reads the word to see both flags. It writes the word to change the enable flag and to acknowledge a tick by writing the done bit as zero.

Ticks come from the `tick_i` input. When `DIV_EN` is set, a second source is added: an internal divider gives one tick every `CLK_HZ / TICK_HZ` system clocks, which is 60 per second by default. The two sources are ORed. Reads have no side effects, so the read data is a continuous view of the word whatever the address. A write is qualified by a byte-lane flag, and only the even (low) byte takes effect.

Top module: `ltick_reg`

## Requirements
- R1: `rd_data_o` shows the done flag at bit 7 and the enable flag at bit 6. Every other bit reads 0.
- R2: A tick in a cycle makes the done flag read 1 after that clock edge.
- R3: A tick raises `irq_o` at the next edge when the enable flag is 1, taking any write in the same cycle into account. `irq_o` never rises in a cycle that has no tick.
- R4: An even-byte write (`wr_en_i`=1, `wr_odd_i`=0) loads the enable flag from bit 6 of `wr_data_i`.
- R5: An even-byte write with bit 7 = 0 clears the done flag. An even-byte write with bit 7 = 1 leaves the done flag unchanged.
- R6: After an even-byte write, `irq_o` is 0 unless the enable flag and the done flag are both 1. A write never raises `irq_o`.
- R7: A write with `wr_odd_i`=1 changes neither `rd_data_o` nor `irq_o`.
- R8: During and after reset, the done flag reads 1, the enable flag reads 0, and `irq_o` is 0.
- R9: With `DIV_EN`=1, the internal ticks come exactly `CLK_HZ / TICK_HZ` clocks apart.
- R10: If a tick and an even-byte write that clears done fall in the same cycle, the tick wins and done stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | External tick pulse, one cycle per tick |
| wr_en_i | input | 1 | Register write strobe |
| wr_odd_i | input | 1 | Write targets the odd byte (ignored) |
| wr_data_i | input | DW | Write data |
| rd_data_o | output | DW | Register read data |
| irq_o | output | 1 | Interrupt request |

## Verification
The flags are held only in flip-flops that drive `rd_data_o` directly. A wrong done or enable value therefore shows on the read bus one clock after the event that caused it. A request that is wrongly set or wrongly kept shows on `irq_o` at that same edge. The request can only be high while both flags read 1, so a wrong request can also be seen as a request that disagrees with the read word. A divider that is off by even one count shifts the spacing between consecutive requests. That error appears within two tick periods.

// File: rtl/ltick_pkg.sv
package ltick_pkg;
  localparam int unsigned DONE_BIT = 7;
  localparam int unsigned IE_BIT   = 6;
endpackage

// File: rtl/ltick_div.sv
module ltick_div #(
  parameter int unsigned CLK_HZ  = 125_000_000,
  parameter int unsigned TICK_HZ = 60
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tick_o
);
  localparam int unsigned TC = (CLK_HZ / TICK_HZ < 2) ? 2 : CLK_HZ / TICK_HZ;
  localparam int unsigned CW = $clog2(TC);

  logic [CW-1:0] cnt_q;
  logic          wrap;

  assign wrap   = (cnt_q == CW'(TC - 1));
  assign tick_o = wrap;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   cnt_q <= '0;
    else if (wrap) cnt_q <= '0;
    else           cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/ltick_csr.sv
module ltick_csr #(
  parameter int unsigned DW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic          wr_en_i,
  input  logic          wr_odd_i,
  input  logic [DW-1:0] wr_data_i,
  output logic          done_o,
  output logic          ie_o,
  output logic          irq_o
);
  import ltick_pkg::*;
  localparam logic [DW-1:0] DONE_M = DW'(1) << DONE_BIT;
  localparam logic [DW-1:0] IE_M   = DW'(1) << IE_BIT;

  logic wr_lo, wd_done, wd_ie;
  logic done_d, ie_d, irq_d;
  logic done_q, ie_q, irq_q;

  assign wr_lo   = wr_en_i & ~wr_odd_i;
  assign wd_done = |(wr_data_i & DONE_M);
  assign wd_ie   = |(wr_data_i & IE_M);

  always_comb begin
    ie_d   = wr_lo ? wd_ie : ie_q;
    done_d = done_q;
    if (wr_lo && !wd_done) done_d = 1'b0;
    if (tick_i)            done_d = 1'b1;  // tick wins over clear
    irq_d = irq_q;
    if (wr_lo && !(ie_d && done_d)) irq_d = 1'b0;
    if (tick_i && ie_d)             irq_d = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_q <= 1'b1;
      ie_q   <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      done_q <= done_d;
      ie_q   <= ie_d;
      irq_q  <= irq_d;
    end
  end

  assign done_o = done_q;
  assign ie_o   = ie_q;
  assign irq_o  = irq_q;
endmodule

// File: rtl/ltick_reg.sv
module ltick_reg #(
  parameter int unsigned DW      = 16,
  parameter bit          DIV_EN  = 1'b1,
  parameter int unsigned CLK_HZ  = 125_000_000,
  parameter int unsigned TICK_HZ = 60
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic          wr_en_i,
  input  logic          wr_odd_i,
  input  logic [DW-1:0] wr_data_i,
  output logic [DW-1:0] rd_data_o,
  output logic          irq_o
);
  import ltick_pkg::*;

  logic div_tick, tick_w, done, ie;

  generate
    if (DIV_EN) begin : g_div
      ltick_div #(.CLK_HZ(CLK_HZ), .TICK_HZ(TICK_HZ)) u_div (
        .clk_i (clk_i),
        .rst_ni(rst_ni),
        .tick_o(div_tick)
      );
    end else begin : g_nodiv
      assign div_tick = 1'b0;
    end
  endgenerate

  assign tick_w = tick_i | div_tick;

  ltick_csr #(.DW(DW)) u_csr (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .tick_i   (tick_w),
    .wr_en_i  (wr_en_i),
    .wr_odd_i (wr_odd_i),
    .wr_data_i(wr_data_i),
    .done_o   (done),
    .ie_o     (ie),
    .irq_o    (irq_o)
  );

  always_comb begin
    rd_data_o           = '0;
    rd_data_o[DONE_BIT] = done;
    rd_data_o[IE_BIT]   = ie;
  end
endmodule

// File: rtl/ltick_chk.sv
module ltick_chk #(
  parameter int unsigned DW = 16
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          tick_w,
  input logic          wr_en_i,
  input logic          wr_odd_i,
  input logic [DW-1:0] wr_data_i,
  input logic [DW-1:0] rd_data_o,
  input logic          irq_o
);
  import ltick_pkg::*;
  localparam logic [DW-1:0] DONE_M = DW'(1) << DONE_BIT;
  localparam logic [DW-1:0] IE_M   = DW'(1) << IE_BIT;

  logic wr_lo, wd_done, wd_ie, r_done, r_ie;
  assign wr_lo   = wr_en_i & ~wr_odd_i;
  assign wd_done = |(wr_data_i & DONE_M);
  assign wd_ie   = |(wr_data_i & IE_M);
  assign r_done  = |(rd_data_o & DONE_M);
  assign r_ie    = |(rd_data_o & IE_M);

  AST_RD_SPARE_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_data_o & ~(DONE_M | IE_M)) == '0); // R1
  AST_TICK_SETS_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_w |=> r_done); // R2
  AST_TICK_RAISES_IRQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_w && (wr_lo ? wd_ie : r_ie) |=> irq_o); // R3
  AST_IRQ_NEEDS_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_w && !irq_o |=> !irq_o); // R3
  AST_WR_LOADS_IE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_lo |=> r_ie == $past(wd_ie)); // R4
  AST_WR_CLEARS_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_lo && !wd_done && !tick_w |=> !r_done); // R5
  AST_WR_KEEPS_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_lo && wd_done && !tick_w |=> r_done == $past(r_done)); // R5
  AST_IRQ_NEEDS_FLAGS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> r_ie && r_done); // R6
  AST_ODD_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i && wr_odd_i && !tick_w |=> $stable(rd_data_o) && $stable(irq_o)); // R7
  AST_TICK_BEATS_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_w && wr_lo && !wd_done |=> r_done); // R10
endmodule

bind ltick_reg ltick_chk #(.DW(DW)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .tick_w   (tick_w),
  .wr_en_i  (wr_en_i),
  .wr_odd_i (wr_odd_i),
  .wr_data_i(wr_data_i),
  .rd_data_o(rd_data_o),
  .irq_o    (irq_o)
);

// File: tb/sim_ltick_reg.sv
`timescale 1ns/1ps
module sim_ltick_reg;
  localparam int DW = 16;
  localparam int TC = 10;

  typedef struct {
    logic [DW-1:0] rd;
    logic          irq;
    string         tag;
  } exp_t;

  logic clk = 1'b0, rst_n = 1'b0;
  logic tick = 1'b0, wr = 1'b0, odd = 1'b0;
  logic [DW-1:0] wd = '0;
  logic [DW-1:0] rd0, rd1;
  logic irq0, irq1;
  logic wr1 = 1'b0;
  logic [DW-1:0] wd1 = '0;

  int n_chk = 0, n_bad = 0, cyc = 0;
  exp_t q[$];
  logic m_done, m_ie, m_irq;

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  ltick_reg #(.DW(DW), .DIV_EN(1'b0)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .wr_en_i(wr),
    .wr_odd_i(odd), .wr_data_i(wd), .rd_data_o(rd0), .irq_o(irq0));

  ltick_reg #(.DW(DW), .DIV_EN(1'b1), .CLK_HZ(600), .TICK_HZ(60)) u1 (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(1'b0), .wr_en_i(wr1),
    .wr_odd_i(1'b0), .wr_data_i(wd1), .rd_data_o(rd1), .irq_o(irq1));

  function automatic logic [DW-1:0] word(logic d, logic e);
    logic [DW-1:0] w = '0;
    w[7] = d;
    w[6] = e;
    return w;
  endfunction

  task automatic check(string tag, logic [DW-1:0] act, logic [DW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // driver: one stimulus cycle, expectation from the requirement model
  task automatic step(logic w, logic o, logic [DW-1:0] d, logic t, string tag);
    exp_t e;
    logic lo;
    @(negedge clk);
    wr = w; odd = o; wd = d; tick = t;
    lo = w & ~o;
    if (lo) m_ie = d[6];
    if (lo && !d[7]) m_done = 1'b0;
    if (t) m_done = 1'b1;
    if (lo && !(m_ie && m_done)) m_irq = 1'b0;
    if (t && m_ie) m_irq = 1'b1;
    e.rd = word(m_done, m_ie);
    e.irq = m_irq;
    e.tag = tag;
    q.push_back(e);
  endtask

  // monitor
  always @(posedge clk) begin
    #2;
    if (rst_n && q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      check({e.tag, " rd"}, rd0, e.rd);
      check({e.tag, " irq"}, {{(DW-1){1'b0}}, irq0}, {{(DW-1){1'b0}}, e.irq});
    end
  end

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin : main
    int t_prev;
    int t_now;
    repeat (3) @(negedge clk);
    check("R8 reset rd", rd0, word(1'b1, 1'b0));
    check("R8 reset irq", {15'd0, irq0}, '0);
    @(negedge clk) rst_n = 1'b1;
    m_done = 1'b1; m_ie = 1'b0; m_irq = 1'b0;

    step(0, 0, 16'h0000, 0, "R1 idle");
    step(1, 0, 16'h0040, 0, "R4 R5 set ie clear done");
    step(0, 0, 16'h0000, 1, "R2 R3 tick with ie");
    step(1, 0, 16'h00C0, 0, "R6 keep irq");
    step(1, 0, 16'h0080, 0, "R6 R4 ie off drops irq");
    step(1, 0, 16'h0040, 0, "R5 clear done");
    step(1, 0, 16'h00C0, 0, "R5 write one keeps done 0");
    step(1, 1, 16'h0000, 0, "R7 odd write");
    step(1, 0, 16'h0040, 1, "R10 tick beats clear");
    step(1, 0, 16'hFFFF, 0, "R1 spare bits");
    step(1, 0, 16'h0000, 0, "R6 clear all");
    step(0, 0, 16'h0000, 1, "R2 R3 tick no ie");
    step(1, 0, 16'h00C0, 0, "R6 write no raise");
    step(0, 0, 16'h0000, 1, "R3 tick raises");
    step(1, 1, 16'h0000, 0, "R7 odd keeps irq");
    step(0, 0, 16'h0000, 0, "R7 idle after");
    wait (q.size() == 0);
    @(negedge clk);

    // divider period on u1
    @(negedge clk); wr1 = 1'b1; wd1 = 16'h0040;
    @(negedge clk); wr1 = 1'b0;
    for (int k = 0; k < 3; k++) begin
      @(posedge irq1);
      t_now = cyc;
      if (k > 0) check("R9 tick period", DW'(t_now - t_prev), DW'(TC));
      t_prev = t_now;
      @(negedge clk); wr1 = 1'b1; wd1 = 16'h0040;
      @(negedge clk); wr1 = 1'b0;
      check("R9 irq acked", {15'd0, irq1}, '0);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule